// File: doc/BRIEF.md
# CAN Bit-Rate Timestamp Timer

This block keeps a 16-bit free-running count for a CAN controller and uses it to timestamp messages. The count advances by one on each bit-clock tick. The tick comes from the controller's bit-timing logic, which supplies it for every bit sent or received during a frame and at the nominal bit rate while the bus is idle. When the controller reports that a frame's identifier field is starting, the block holds the current count as a pending capture.

When that frame later finishes successfully, the block issues a single-cycle write toward the message buffer store. The write carries the buffer index and the held count. If the frame ends in failure, the pending capture is dropped and nothing is written.

The CPU reads the live count at any time. The CPU may also overwrite the count, and counting resumes from the written value.

Top module: `can_tstamp_timer`

## Requirements
- R1: During and after synchronous reset (active low) the count reads 0 and no timestamp write is issued.
- R2: A cycle with `bit_tick` high and no CPU write makes the count one higher on the next cycle.
- R3: The count wraps from 0xFFFF to 0x0000 on a tick.
- R4: A cycle with neither `bit_tick` nor a CPU write leaves the count unchanged.
- R5: `cpu_wr_en` loads `cpu_wr_data` into the count on the next cycle, even if `bit_tick` is high in the same cycle. Later ticks count up from the loaded value.
- R6: `id_start` captures the count value present in that same cycle, before any increment made by a tick in that cycle.
- R7: `frame_ok` with a capture pending produces, on the next cycle, `ts_wr_en` high for exactly one cycle. That write carries `frame_buf` as `ts_wr_idx` and the captured value as `ts_wr_data`. The pending capture is then consumed, so a further `frame_ok` writes nothing.
- R8: `frame_fail` discards the pending capture; it wins over `frame_ok` in the same cycle, and no write follows.
- R9: `frame_ok` with no capture pending issues no write.
- R10: A new `id_start` replaces any pending capture. If it coincides with `frame_ok`, the old capture is written and the new one stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_tick | input | 1 | One-cycle strobe per CAN bit time |
| id_start | input | 1 | Identifier field of a frame begins |
| frame_ok | input | 1 | Current frame completed successfully |
| frame_fail | input | 1 | Current frame failed or was aborted |
| frame_buf | input | IDX_W | Message buffer index of the current frame |
| cpu_wr_en | input | 1 | CPU write of the count |
| cpu_wr_data | input | CNT_W | Value written by the CPU |
| cpu_rd_data | output | CNT_W | Live count |
| ts_wr_en | output | 1 | Timestamp write strobe |
| ts_wr_idx | output | IDX_W | Buffer index for the timestamp write |
| ts_wr_data | output | CNT_W | Timestamp value |

## Verification
The bench targets the wrap at 0xFFFF, which a design with a wrong width or saturation would get wrong by sticking or overflowing. It also targets a CPU write that lands together with a tick; a design with reversed priority would read one higher than the written value. A tick that coincides with identifier start exposes a capture taken after the increment, because the stored timestamp would then be off by one. Failed frames, a repeated success, a success with nothing pending, an overriding identifier start, and an identifier start that coincides with success are all checked against a queue of expected writes. A design that leaks, duplicates or misroutes a timestamp write shows up as an unexpected, missing or mismatched item in that queue.

// File: rtl/tstamp_pkg.sv
// Shared types for the timestamp timer.
// Assumes: nothing beyond IEEE 1800-2017.
package tstamp_pkg;
    typedef enum logic {
        CAP_EMPTY = 1'b0,
        CAP_HELD  = 1'b1
    } cap_state_e;
endpackage

// File: rtl/tstamp_counter.sv
// Free-running up counter advanced by bit ticks, loadable by the CPU.
// Assumes: bit_tick is a one-cycle strobe; a load wins over a tick.
module tstamp_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Count register: reset, load, or increment with natural wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (tick)
            count <= count + ONE;
    end
endmodule

// File: rtl/tstamp_capture.sv
// Holds the count seen at identifier start and commits it on success.
// Assumes: fail wins over ok; a commit uses the capture held before
// any same-cycle identifier start, which then re-arms.
module tstamp_capture
    import tstamp_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             id_start,
    input  logic             frame_ok,
    input  logic             frame_fail,
    input  logic [IDX_W-1:0] frame_buf,
    input  logic [CNT_W-1:0] count,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [CNT_W-1:0] wr_data
);
    cap_state_e       state;
    logic [CNT_W-1:0] held;
    logic             commit;

    // Decide whether a timestamp is committed this cycle.
    always_comb commit = frame_ok && !frame_fail && (state == CAP_HELD);

    // Pending capture bookkeeping: arm on identifier start, clear on end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CAP_EMPTY;
            held  <= '0;
        end else if (id_start) begin
            state <= CAP_HELD;
            held  <= count;
        end else if (commit || frame_fail) begin
            state <= CAP_EMPTY;
        end
    end

    // Registered one-cycle write toward the message buffer store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= commit;
            if (commit) begin
                wr_idx  <= frame_buf;
                wr_data <= held;
            end
        end
    end
endmodule

// File: rtl/can_tstamp_timer.sv
// Top of the timestamp timer: counter plus capture/commit stage.
// Assumes: strobes are synchronous to clk and one cycle wide.
module can_tstamp_timer #(
    parameter int CNT_W = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             id_start,
    input  logic             frame_ok,
    input  logic             frame_fail,
    input  logic [IDX_W-1:0] frame_buf,
    input  logic             cpu_wr_en,
    input  logic [CNT_W-1:0] cpu_wr_data,
    output logic [CNT_W-1:0] cpu_rd_data,
    output logic             ts_wr_en,
    output logic [IDX_W-1:0] ts_wr_idx,
    output logic [CNT_W-1:0] ts_wr_data
);
    logic [CNT_W-1:0] count;

    tstamp_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (bit_tick),
        .load     (cpu_wr_en),
        .load_val (cpu_wr_data),
        .count    (count)
    );

    tstamp_capture #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .id_start   (id_start),
        .frame_ok   (frame_ok),
        .frame_fail (frame_fail),
        .frame_buf  (frame_buf),
        .count      (count),
        .wr_en      (ts_wr_en),
        .wr_idx     (ts_wr_idx),
        .wr_data    (ts_wr_data)
    );

    // Expose the live count to the CPU.
    always_comb cpu_rd_data = count;
endmodule

// File: rtl/can_tstamp_timer_chk.sv
// Property checker for can_tstamp_timer, attached by bind.
module can_tstamp_timer_chk #(
    parameter int CNT_W = 16,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_tick,
    input logic             frame_ok,
    input logic             frame_fail,
    input logic             cpu_wr_en,
    input logic [CNT_W-1:0] cpu_wr_data,
    input logic [CNT_W-1:0] cpu_rd_data,
    input logic             ts_wr_en
);
    AST_TICK_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !cpu_wr_en) |=> cpu_rd_data == CNT_W'($past(cpu_rd_data) + CNT_W'(1))); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_tick && !cpu_wr_en) |=> $stable(cpu_rd_data)); // R4
    AST_CPU_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr_en |=> cpu_rd_data == $past(cpu_wr_data)); // R5
    AST_WR_AFTER_OK: assert property (@(posedge clk) disable iff (!rst_n)
        ts_wr_en |-> $past(frame_ok)); // R7
    AST_FAIL_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        frame_fail |=> !ts_wr_en); // R8
endmodule

bind can_tstamp_timer can_tstamp_timer_chk #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_tick    (bit_tick),
    .frame_ok    (frame_ok),
    .frame_fail  (frame_fail),
    .cpu_wr_en   (cpu_wr_en),
    .cpu_wr_data (cpu_wr_data),
    .cpu_rd_data (cpu_rd_data),
    .ts_wr_en    (ts_wr_en)
);

// File: tb/can_tstamp_timer_bench.sv
`timescale 1ns/1ps
module can_tstamp_timer_bench;
    localparam int CW = 16;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_tick = 1'b0, id_start = 1'b0, frame_ok = 1'b0, frame_fail = 1'b0;
    logic [IW-1:0] frame_buf = '0;
    logic          cpu_wr_en = 1'b0;
    logic [CW-1:0] cpu_wr_data = '0;
    logic [CW-1:0] cpu_rd_data;
    logic          ts_wr_en;
    logic [IW-1:0] ts_wr_idx;
    logic [CW-1:0] ts_wr_data;

    typedef struct {
        logic [IW-1:0] idx;
        logic [CW-1:0] val;
        string         tag;
    } ts_item_t;

    ts_item_t      exp_q[$];
    int            n_run = 0, n_fail = 0;
    logic [CW-1:0] m_cnt = '0, m_cap = '0;
    bit            m_held = 0;
    bit            done = 0;

    always #2.5 clk = ~clk;

    can_tstamp_timer #(.CNT_W(CW), .IDX_W(IW)) u_can_tstamp_timer (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .id_start(id_start),
        .frame_ok(frame_ok), .frame_fail(frame_fail), .frame_buf(frame_buf),
        .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data), .cpu_rd_data(cpu_rd_data),
        .ts_wr_en(ts_wr_en), .ts_wr_idx(ts_wr_idx), .ts_wr_data(ts_wr_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: at a falling edge, check the count, apply inputs, update the model.
    task automatic step(input string tag, input bit tk, input bit ids, input bit ok,
                        input bit fl, input logic [IW-1:0] idx,
                        input bit wr, input logic [CW-1:0] wd);
        ts_item_t it;
        @(negedge clk);
        check(tag, 32'(cpu_rd_data), 32'(m_cnt));
        bit_tick = tk; id_start = ids; frame_ok = ok; frame_fail = fl;
        frame_buf = idx; cpu_wr_en = wr; cpu_wr_data = wd;
        if (ok && !fl && m_held) begin
            it.idx = idx; it.val = m_cap; it.tag = tag;
            exp_q.push_back(it);
            m_held = 0;
        end else if (fl) begin
            m_held = 0;
        end
        if (ids) begin
            m_cap = m_cnt;
            m_held = 1;
        end
        if (wr) m_cnt = wd;
        else if (tk) m_cnt = m_cnt + 16'd1;
    endtask

    task automatic ticks(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 1, 0, 0, 0, '0, 0, '0);
    endtask

    // Monitor: pop and compare each timestamp write as it appears.
    always @(negedge clk) begin
        if (rst_n && ts_wr_en) begin
            if (exp_q.size() == 0) begin
                n_run++; n_fail++;
                $display("FAIL R8 or R9 unexpected write actual idx=%0h val=%0h expected none",
                         ts_wr_idx, ts_wr_data);
            end else begin
                ts_item_t e;
                e = exp_q.pop_front();
                check({e.tag, " idx"}, 32'(ts_wr_idx), 32'(e.idx));
                check({e.tag, " val"}, 32'(ts_wr_data), 32'(e.val));
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 count", 32'(cpu_rd_data), 32'h0);
        check("R1 ts_wr_en", 32'(ts_wr_en), 32'h0);
        rst_n = 1'b1;
        ticks("R2", 5);
        step("R4", 0, 0, 0, 0, '0, 0, '0);
        step("R4", 0, 0, 0, 0, '0, 0, '0);
        step("R5", 1, 0, 0, 0, '0, 1, 16'h1234);
        ticks("R5", 2);
        step("R3", 0, 0, 0, 0, '0, 1, 16'hFFFE);
        ticks("R3", 3);
        step("R6", 0, 1, 0, 0, '0, 0, '0);
        ticks("R6", 4);
        step("R7", 1, 0, 1, 0, 4'h3, 0, '0);
        step("R7", 1, 0, 1, 0, 4'h5, 0, '0);
        step("R7", 0, 0, 0, 0, '0, 0, '0);
        step("R8", 1, 1, 0, 0, '0, 0, '0);
        ticks("R8", 3);
        step("R8", 1, 0, 0, 1, 4'h2, 0, '0);
        step("R8", 1, 0, 1, 0, 4'h2, 0, '0);
        step("R8", 1, 1, 0, 0, '0, 0, '0);
        step("R8", 1, 0, 1, 1, 4'h6, 0, '0);
        step("R9", 1, 0, 1, 0, 4'h7, 0, '0);
        step("R10", 1, 1, 0, 0, '0, 0, '0);
        ticks("R10", 3);
        step("R10", 0, 1, 0, 0, '0, 0, '0);
        ticks("R10", 2);
        step("R10", 1, 0, 1, 0, 4'h9, 0, '0);
        step("R6", 1, 1, 0, 0, '0, 0, '0);
        ticks("R6", 2);
        step("R6", 0, 0, 1, 0, 4'hA, 0, '0);
        step("R10", 1, 1, 0, 0, '0, 0, '0);
        ticks("R10", 2);
        step("R10", 1, 1, 1, 0, 4'hB, 0, '0);
        ticks("R10", 2);
        step("R10", 1, 0, 1, 0, 4'hC, 0, '0);
        ticks("R2", 4);
        check("R7 pending writes", 32'(exp_q.size()), 32'h0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule